// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block makes a timer's counter follow an external trigger instead of running on its own. Four trigger lines come from the trigger outputs of neighbouring timers. A two-bit select picks one of them. The selected line and a pair of quadrature encoder inputs each pass through a two-flop synchronizer. A three-bit slave-mode code then sets how the trigger acts on the counter. In free-running mode the trigger is ignored. In gated mode the trigger level qualifies counting. In triggered mode a rising edge sets the run bit in hardware. In external-clock mode each rising edge gives one count. In encoder mode the counter follows the encoder phase in both directions.

The counter itself is a plain attached register. It has a synchronous load port and a top (reload) value, and it wraps at both ends. The block brings out the run bit, the count-enable qualification and the per-cycle up and down strobes that drive the counter.

A three-state run machine holds the run bit. In `ST_HALT` the run bit is clear and no hardware start is possible. In `ST_ARMED` the run bit is clear and mode 6 is waiting for a rising edge. In `ST_RUN` the run bit is set. The transitions are:
- `go_sw`: HALT or ARMED to RUN, on a software set.
- `go_edge`: ARMED to RUN, on a trigger rising edge.
- `arm`: HALT to ARMED, when the mode becomes 6.
- `disarm`: ARMED to HALT, when the mode leaves 6.
- `stop`: RUN to HALT, or to ARMED in mode 6, on a software clear.

Top module: `trig_slave_ctrl`

## Requirements
- R1: After reset, `count` is 0, `run` is 0, and `cnt_up` and `cnt_down` are 0.
- R2: A `run_set` pulse sets `run` and a `run_clr` pulse clears it. When both are high in the same cycle, the clear wins. In mode 0, `count` rises by one every cycle while `run` is 1 and holds while `run` is 0.
- R3: `trig_sel` picks `trig_in[trig_sel]`. Each trigger passes through two flops, so in gated mode a fall of the selected line still allows exactly two more counts.
- R4: In mode 5 (gated), the counter counts one per cycle only while the selected trigger is high. It holds its value while the trigger is low, and it resumes from the held value.
- R5: In mode 6 (triggered), a rising edge on the selected trigger sets `run`. A trigger that is already high when the mode is entered does not set it. After a software clear, `run` stays 0 until the next rising edge.
- R6: In mode 7 (external clock), `count` rises by exactly one for each rising edge of the selected trigger.
- R7: In mode 3 (encoder), the pair {enc_a, enc_b} stepping 00→10→11→01→00 counts up by one per step, which gives four counts per input period. The reverse order counts down. A step in which both inputs change gives no count.
- R8: Counting up from `cnt_top` gives 0. Counting down from 0 gives `cnt_top`.
- R9: `cnt_load` writes `cnt_load_val` into `count` at the next edge, and it takes priority over any count in that cycle.
- R10: Mode codes 1, 2 and 4 behave as mode 0.
- R11: Trigger lines that are not selected have no effect on counting.
- R12: While `run` is 0, no count happens in any mode, including encoder steps and external-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NUM_TRIG | Trigger lines from neighbouring timers (asynchronous) |
| trig_sel | input | SEL_W | Index of the trigger line in use |
| slave_mode | input | 3 | Slave mode code: 0 free, 3 encoder, 5 gated, 6 triggered, 7 external clock |
| run_set | input | 1 | Software set of the run bit (pulse) |
| run_clr | input | 1 | Software clear of the run bit (pulse) |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| cnt_load | input | 1 | Load the counter |
| cnt_load_val | input | CNT_W | Value to load |
| cnt_top | input | CNT_W | Reload value: the counting ceiling and the down-wrap target |
| count | output | CNT_W | Counter value |
| run | output | 1 | Counter enable bit |
| cnt_qual | output | 1 | Count-enable qualification (run bit and gate level) |
| cnt_up | output | 1 | Increment strobe for this cycle |
| cnt_down | output | 1 | Decrement strobe for this cycle |

## Verification
The assertions assume that software holds `slave_mode` and `trig_sel` steady while the counter runs. They also assume that the encoder inputs hold each level for several cycles, so the synchronizers see every phase step. The stimulus changes the mode and select only while `run` is 0, or just before a run is started. It holds every encoder and trigger level for at least three cycles. The stimulus brings in both-inputs-changing encoder steps on purpose, to check that they are rejected.

// File: rtl/trig_slave_pkg.sv
package trig_slave_pkg;

    typedef enum logic [2:0] {
        SM_FREE   = 3'd0,
        SM_QUAD   = 3'd3,
        SM_GATE   = 3'd5,
        SM_TRIG   = 3'd6,
        SM_EXTCLK = 3'd7
    } slave_mode_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

endpackage

// File: rtl/stc_sync.sv
module stc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d[g]};
            end
        end
        assign q[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/stc_trig_pick.sv
module stc_trig_pick #(
    parameter int NUM   = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   trig_s,
    input  logic [SEL_W-1:0] sel,
    output logic             level,
    output logic             rise
);
    logic prev_q;

    assign level = trig_s[sel];
    assign rise  = level & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level;
        end
    end

    // R5
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && $stable(sel)) |=> !rise);
endmodule

// File: rtl/stc_quad.sv
module stc_quad (
    input  logic clk,
    input  logic rst_n,
    input  logic a_s,
    input  logic b_s,
    output logic step,
    output logic up
);
    logic ap_q, bp_q;
    logic a_chg, b_chg;

    assign a_chg = a_s ^ ap_q;
    assign b_chg = b_s ^ bp_q;
    assign step  = a_chg ^ b_chg;
    assign up    = a_s ^ bp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_q <= 1'b0;
            bp_q <= 1'b0;
        end else begin
            ap_q <= a_s;
            bp_q <= b_s;
        end
    end

    // R7
    no_double_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chg && b_chg) |-> !step);
endmodule

// File: rtl/stc_run_fsm.sv
module stc_run_fsm
    import trig_slave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       sw_set,
    input  logic       sw_clr,
    input  logic       trig_rise,
    output logic       run
);
    run_state_e state_q, state_d;
    logic       trig_mode;

    assign trig_mode = (mode == SM_TRIG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (sw_clr)          state_d = ST_HALT;
                else if (sw_set)     state_d = ST_RUN;
                else if (trig_mode)  state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (sw_clr)                   state_d = trig_mode ? ST_ARMED : ST_HALT;
                else if (sw_set)              state_d = ST_RUN;
                else if (!trig_mode)          state_d = ST_HALT;
                else if (trig_rise)           state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sw_clr)          state_d = trig_mode ? ST_ARMED : ST_HALT;
            end
            default:                 state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end

    // R2
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !run);

    // R2
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && !sw_clr) |=> run);

    // R5
    edge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && trig_mode && trig_rise && !sw_clr) |=> run);
endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (inc) begin
            cnt_d = (cnt_q >= top) ? '0 : cnt_q + 1'b1;
        end else if (dec) begin
            cnt_d = (cnt_q == '0) ? top : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R8
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt_q == top) |=> cnt_q == '0);

    // R8
    wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !load && cnt_q == '0) |=> cnt_q == $past(top));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/trig_slave_ctrl.sv
module trig_slave_ctrl
    import trig_slave_pkg::*;
#(
    parameter int NUM_TRIG    = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [2:0]          slave_mode,
    input  logic                run_set,
    input  logic                run_clr,
    input  logic                enc_a,
    input  logic                enc_b,
    input  logic                cnt_load,
    input  logic [CNT_W-1:0]    cnt_load_val,
    input  logic [CNT_W-1:0]    cnt_top,
    output logic [CNT_W-1:0]    count,
    output logic                run,
    output logic                cnt_qual,
    output logic                cnt_up,
    output logic                cnt_down
);
    logic [NUM_TRIG-1:0] trig_s;
    logic [1:0]          enc_s;
    logic                trig_lvl, trig_rise;
    logic                q_step, q_up;

    stc_sync #(.W(NUM_TRIG), .STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .d(trig_in), .q(trig_s)
    );

    stc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_enc_sync (
        .clk(clk), .rst_n(rst_n), .d({enc_b, enc_a}), .q(enc_s)
    );

    stc_trig_pick #(.NUM(NUM_TRIG), .SEL_W(SEL_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .trig_s(trig_s), .sel(trig_sel),
        .level(trig_lvl), .rise(trig_rise)
    );

    stc_quad u_quad (
        .clk(clk), .rst_n(rst_n), .a_s(enc_s[0]), .b_s(enc_s[1]),
        .step(q_step), .up(q_up)
    );

    stc_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(slave_mode), .sw_set(run_set),
        .sw_clr(run_clr), .trig_rise(trig_rise), .run(run)
    );

    always_comb begin
        cnt_qual = run;
        cnt_up   = 1'b0;
        cnt_down = 1'b0;
        case (slave_mode)
            SM_QUAD: begin
                cnt_up   = run & q_step & q_up;
                cnt_down = run & q_step & ~q_up;
            end
            SM_GATE: begin
                cnt_qual = run & trig_lvl;
                cnt_up   = run & trig_lvl;
            end
            SM_EXTCLK: begin
                cnt_up   = run & trig_rise;
            end
            default: begin
                cnt_up   = run;
            end
        endcase
    end

    stc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_up), .dec(cnt_down),
        .load(cnt_load), .load_val(cnt_load_val), .top(cnt_top), .cnt(count)
    );

    // R12
    stopped_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(cnt_up || cnt_down));

    // R4
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode == SM_GATE && !trig_lvl) |-> !cnt_up);

    // R7
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_down));
endmodule

// File: tb/trig_slave_ctrl_bench.sv
module trig_slave_ctrl_bench;
    localparam int NT = 4;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NT-1:0] trig;
    logic [1:0]    sel;
    logic [2:0]    mode;
    logic          rset, rclr, ea, eb, ld;
    logic [W-1:0]  ldv, top;
    logic [W-1:0]  count;
    logic          run, qual, up, down;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    trig_slave_ctrl #(.NUM_TRIG(NT), .CNT_W(W)) u_trig_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_in(trig), .trig_sel(sel),
        .slave_mode(mode), .run_set(rset), .run_clr(rclr),
        .enc_a(ea), .enc_b(eb), .cnt_load(ld), .cnt_load_val(ldv),
        .cnt_top(top), .count(count), .run(run), .cnt_qual(qual),
        .cnt_up(up), .cnt_down(down)
    );

    // encoder vectors: [3:2] = {enc_a, enc_b}, [1:0] = 0 none, 1 up, 2 down
    localparam logic [3:0] ENC_VEC [12] = '{
        4'b10_01, 4'b11_01, 4'b01_01, 4'b00_01,
        4'b01_10, 4'b11_10, 4'b10_10, 4'b00_10,
        4'b11_00, 4'b00_00, 4'b00_00, 4'b10_01
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_set();
        rset = 1'b1; wait_n(1); rset = 1'b0;
    endtask

    task automatic pulse_clr();
        rclr = 1'b1; wait_n(1); rclr = 1'b0;
    endtask

    task automatic trig_pulses(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            trig[idx] = 1'b1; wait_n(3);
            trig[idx] = 1'b0; wait_n(3);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        int held;
        int exp;
        rst_n = 1'b0; trig = '0; sel = '0; mode = 3'd0; rset = 0; rclr = 0;
        ea = 0; eb = 0; ld = 0; ldv = '0; top = 16'd1000;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 run", int'(run), 0);
        chk("R1 up", int'(up), 0);
        chk("R1 down", int'(down), 0);

        // R2 free-running counting
        pulse_set(); wait_n(2);
        c0 = int'(count); wait_n(10);
        chk("R2 free count", int'(count), c0 + 10);
        chk("R2 up strobe", int'(up), 1);
        pulse_clr(); wait_n(2);
        chk("R2 clear", int'(run), 0);
        c0 = int'(count); wait_n(5);
        chk("R2 hold while stopped", int'(count), c0);
        rset = 1; rclr = 1; wait_n(1); rset = 0; rclr = 0; wait_n(2);
        chk("R2 clear priority", int'(run), 0);

        // R10 reserved mode code acts as free
        mode = 3'd4; pulse_set(); wait_n(2);
        c0 = int'(count); wait_n(10);
        chk("R10 mode 4", int'(count), c0 + 10);
        pulse_clr(); mode = 3'd0; wait_n(2);

        // R9 load
        ld = 1; ldv = 16'd5; wait_n(1); ld = 0;
        chk("R9 load stopped", int'(count), 5);
        pulse_set(); wait_n(3);
        ld = 1; ldv = 16'd77;
        for (int k = 0; k < 3; k++) begin
            wait_n(1);
            chk("R9 load priority", int'(count), 77);
        end
        ld = 0; pulse_clr(); wait_n(2);

        // R4 / R11 / R3 gated mode on line 2
        mode = 3'd5; sel = 2'd2; trig = 4'b0000;
        pulse_set(); wait_n(5);
        c0 = int'(count);
        trig = 4'b1011; wait_n(10);
        chk("R11 other lines ignored", int'(count), c0);
        trig = 4'b0100; wait_n(4);
        c0 = int'(count); wait_n(10);
        chk("R4 gate high counts", int'(count), c0 + 10);
        trig = 4'b0000; c0 = int'(count); wait_n(5);
        chk("R3 two-flop latency", int'(count), c0 + 2);
        held = int'(count); wait_n(10);
        chk("R4 gate low holds", int'(count), held);
        trig = 4'b0100; wait_n(4);
        chk("R4 resume from held", int'(count), held + 2);
        trig = 4'b0000; pulse_clr(); mode = 3'd0; wait_n(4);

        // R5 triggered mode on line 1
        sel = 2'd1; trig[1] = 1'b1; wait_n(5);
        mode = 3'd6; wait_n(10);
        chk("R5 level does not start", int'(run), 0);
        trig[1] = 1'b0; wait_n(5);
        c0 = int'(count);
        chk("R5 armed stopped", int'(run), 0);
        trig[1] = 1'b1; wait_n(3);
        chk("R5 edge sets run", int'(run), 1);
        wait_n(2);
        chk("R5 counting after edge", int'(count), c0 + 2);
        pulse_clr(); wait_n(5);
        chk("R5 stays stopped after clear", int'(run), 0);
        trig[1] = 1'b0; mode = 3'd0; wait_n(4);

        // R6 external clock on line 3
        mode = 3'd7; sel = 2'd3;
        pulse_set(); wait_n(3);
        c0 = int'(count);
        trig_pulses(3, 5); wait_n(4);
        chk("R6 one count per edge", int'(count), c0 + 5);
        pulse_clr(); wait_n(2);
        c0 = int'(count);
        trig_pulses(3, 3); wait_n(4);
        chk("R12 extclk stopped", int'(count), c0);

        // R7 encoder table
        mode = 3'd3; top = 16'd1000;
        ld = 1; ldv = 16'd10; wait_n(1); ld = 0;
        ea = 0; eb = 0; wait_n(5);
        pulse_set(); wait_n(2);
        exp = 10;
        for (int i = 0; i < 12; i++) begin
            ea = ENC_VEC[i][3]; eb = ENC_VEC[i][2];
            wait_n(6);
            if (ENC_VEC[i][1:0] == 2'd1) exp = exp + 1;
            if (ENC_VEC[i][1:0] == 2'd2) exp = exp - 1;
            chk("R7 encoder step", int'(count), exp);
        end

        // R8 wrap both ways (state is now ab=10)
        top = 16'd20;
        ea = 1; eb = 1; wait_n(6);
        ld = 1; ldv = 16'd20; wait_n(1); ld = 0; wait_n(2);
        ea = 0; eb = 1; wait_n(6);
        chk("R8 up wrap to zero", int'(count), 0);
        ea = 1; eb = 1; wait_n(6);
        chk("R8 down wrap to top", int'(count), 20);

        // R12 encoder stopped
        pulse_clr(); wait_n(2);
        c0 = int'(count);
        ea = 1; eb = 0; wait_n(6);
        chk("R12 encoder stopped", int'(count), c0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule